// File: doc/BRIEF.md
# Filtered Dual-Threshold Power-On Reset

This block drives an active-low reset for on-chip logic. It works from two digitized supply-monitor flags. `above_hi_i` reports that the core rail sits over the upper trip level. `below_lo_i` reports that the rail sits under the lower trip level. The upper level lies above the lower one, so in the band between them neither flag is set.

Reset is held from power-up. It is let go only after two things have happened in order. First, the rail must stay over the upper level for a qualify time. Second, a further hold-off time must pass. Once reset is released, it is pulled back only when the rail has stayed under the lower level for longer than a glitch-filter time. Shorter dips are ignored on purpose.

Both flags are treated as asynchronous and pass through a synchronizer before use. All times are parameters counted in clock cycles: `HI_QUAL_CYC`, `HOLD_CYC` and `LO_QUAL_CYC`. The block has no reset input. All of its registers start from their declared initial values.

Top module: `rail_por_gen`

## Requirements
- R1: `por_rst_n_o` is 0 from the first clock cycle, and stays 0 until the release condition of R3 is met.
- R2: Each flag passes through a two-flop synchronizer. A flag value sampled at clock edge k reaches the control logic at edge k+2. All latencies below include this delay.
- R3: While reset is asserted, suppose `above_hi_i` is sampled 1 at every edge from k through k+HI_QUAL_CYC+HOLD_CYC+1. Then `por_rst_n_o` goes to 1 at edge k+HI_QUAL_CYC+HOLD_CYC+3. In this case k is the first edge of that high run.
- R4: While reset is asserted, a single edge that samples `above_hi_i` as 0 restarts both the qualify and the hold-off timing. A full new run of R3 is then required. A run of only HI_QUAL_CYC+HOLD_CYC+1 samples does not release reset.
- R5: While reset is released, suppose `below_lo_i` is sampled 1 at every edge from k through k+LO_QUAL_CYC. Then `por_rst_n_o` goes to 0 at edge k+LO_QUAL_CYC+2.
- R6: While reset is released, a run of at most LO_QUAL_CYC low samples has no effect on `por_rst_n_o`. A single edge that samples `below_lo_i` as 0 restarts the low count.
- R7: While reset is released, the mid band (both flags 0) and the high flag keep `por_rst_n_o` at 1 for any length of time.
- R8: After a re-assertion, release again requires the complete sequence of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| above_hi_i | input | 1 | Asynchronous flag: rail above upper trip level |
| below_lo_i | input | 1 | Asynchronous flag: rail below lower trip level |
| por_rst_n_o | output | 1 | Active-low reset, registered |

## Verification
A phase register left in the wrong state shows directly as a wrong level on `por_rst_n_o`. A high-qualify timer that counts too far or not far enough moves the release edge away from the predicted cycle. A hold-off timer fault does the same. A low timer that fails to restart lets a train of short dips pull reset, which should never happen. Every such fault appears within two cycles of the mis-timed event, so the bench compares the output against a streak-based model at every cycle. It also times the release and trip edges directly.

// File: rtl/rail_por_pkg.sv
package rail_por_pkg;

  typedef enum logic [1:0] {
    PH_WAIT_HI  = 2'd0,
    PH_HOLDOFF  = 2'd1,
    PH_ACTIVE   = 2'd2
  } por_phase_e;

  // Counter width able to hold the value 'limit'.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Consecutive high samples needed for release (qualify + hold + two confirm edges).
  function automatic int hi_streak_need(input int hi_q, input int hold);
    return hi_q + hold + 2;
  endfunction

  // Consecutive low samples needed to trip (strictly longer than the filter).
  function automatic int lo_streak_need(input int lo_q);
    return lo_q + 1;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q = '0;

  always_ff @(posedge clk) begin
    sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/dwell_timer.sv
module dwell_timer
  import rail_por_pkg::*;
#(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic run_i,
  output logic done_o
);

  localparam int W = cnt_width(LIMIT);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q = '0;

  // Counts while run_i holds, saturates at LIMIT, clears on any gap.
  always_ff @(posedge clk) begin
    if (!run_i)
      cnt_q <= '0;
    else if (cnt_q != LIM_V)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM_V);

  // R4
  always_comb begin
    count_bound_chk: assert (cnt_q <= LIM_V);
  end

endmodule

// File: rtl/rail_por_gen.sv
module rail_por_gen
  import rail_por_pkg::*;
#(
  parameter int HI_QUAL_CYC = 64,
  parameter int HOLD_CYC    = 12,
  parameter int LO_QUAL_CYC = 352,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic above_hi_i,
  input  logic below_lo_i,
  output logic por_rst_n_o
);

  logic hi_s, lo_s;
  logic hi_run, hold_run, lo_run;
  logic hi_done, hold_done, lo_done;
  logic release_evt, trip_evt;

  por_phase_e phase_q = PH_WAIT_HI;
  por_phase_e phase_d;
  logic rst_n_q = 1'b0;
  logic live_q  = 1'b0;

  flag_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
    .clk (clk), .d_i (above_hi_i), .q_o (hi_s)
  );
  flag_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
    .clk (clk), .d_i (below_lo_i), .q_o (lo_s)
  );

  assign hi_run   = (phase_q == PH_WAIT_HI) && hi_s;
  assign hold_run = (phase_q == PH_HOLDOFF) && hi_s;
  assign lo_run   = (phase_q == PH_ACTIVE)  && lo_s;

  dwell_timer #(.LIMIT(HI_QUAL_CYC)) u_hi_tmr (
    .clk (clk), .run_i (hi_run), .done_o (hi_done)
  );
  dwell_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
    .clk (clk), .run_i (hold_run), .done_o (hold_done)
  );
  dwell_timer #(.LIMIT(LO_QUAL_CYC)) u_lo_tmr (
    .clk (clk), .run_i (lo_run), .done_o (lo_done)
  );

  // Named events for the checks below.
  assign release_evt = (phase_q == PH_HOLDOFF) && hi_s && hold_done;
  assign trip_evt    = (phase_q == PH_ACTIVE) && lo_s && lo_done;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_WAIT_HI: if (hi_done && hi_s) phase_d = PH_HOLDOFF;
      PH_HOLDOFF: begin
        if (!hi_s)          phase_d = PH_WAIT_HI;
        else if (hold_done) phase_d = PH_ACTIVE;
      end
      PH_ACTIVE:  if (trip_evt) phase_d = PH_WAIT_HI;
      default:    phase_d = PH_WAIT_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
    rst_n_q <= (phase_d == PH_ACTIVE);
    live_q  <= 1'b1;
  end

  assign por_rst_n_o = rst_n_q;

  // R3
  release_gate_chk: assert property (@(posedge clk) disable iff (!live_q)
    $rose(por_rst_n_o) |-> $past(release_evt));

  // R5
  trip_gate_chk: assert property (@(posedge clk) disable iff (!live_q)
    $fell(por_rst_n_o) |-> $past(trip_evt));

  // R4
  hold_low_chk: assert property (@(posedge clk) disable iff (!live_q)
    (!por_rst_n_o && !hi_s) |=> !por_rst_n_o);

  // R7
  dip_ignore_chk: assert property (@(posedge clk) disable iff (!live_q)
    (por_rst_n_o && !lo_s) |=> por_rst_n_o);

endmodule

// File: tb/tb_rail_por_gen.sv
`timescale 1ns/1ps
module tb_rail_por_gen;

  localparam int HQ = 12;
  localparam int HD = 5;
  localparam int LQ = 20;

  logic clk = 1'b0;
  logic hi_drv = 1'b0;
  logic lo_drv = 1'b0;
  logic rst_n;

  always #2 clk = ~clk;

  rail_por_gen #(.HI_QUAL_CYC(HQ), .HOLD_CYC(HD), .LO_QUAL_CYC(LQ)) dut (
    .clk (clk), .above_hi_i (hi_drv), .below_lo_i (lo_drv), .por_rst_n_o (rst_n)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit track_on = 1'b1;
  bit done_flag = 1'b0;

  // Bench-side arithmetic, written from the requirements.
  function automatic int need_hi();  return HQ + HD + 2; endfunction
  function automatic int need_lo();  return LQ + 1;      endfunction
  function automatic int rel_negedges(); return HQ + HD + 4; endfunction
  function automatic int trip_negedges(); return LQ + 3; endfunction

  // Streak model: trigger at a threshold edge, output follows two edges later.
  int  s_hi = 0, s_lo = 0, rel_cd = 0, trip_cd = 0;
  bit  mode = 1'b0;
  always @(posedge clk) begin
    if (rel_cd != 0) begin rel_cd--; if (rel_cd == 0) mode = 1'b1; end
    if (trip_cd != 0) begin trip_cd--; if (trip_cd == 0) mode = 1'b0; end
    s_hi = hi_drv ? s_hi + 1 : 0;
    s_lo = lo_drv ? s_lo + 1 : 0;
    if (!mode && rel_cd == 0 && s_hi == need_hi()) rel_cd = 2;
    if (mode && trip_cd == 0 && s_lo == need_lo()) trip_cd = 2;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (track_on && !done_flag) chk(cur_req, rst_n, mode);

  task automatic hold_lvl(input bit h, input bit l, input int n);
    hi_drv = h; lo_drv = l;
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input bit h, input bit l, input logic target, output int n);
    hi_drv = h; lo_drv = l; n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); n++;
      if (rst_n === target) break;
    end
  endtask

  task automatic summary();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd20250611));
    @(negedge clk);
    chk("R1", rst_n, 1'b0);
    cur_req = "R1";
    hold_lvl(0, 0, 10);
    chk("R1", rst_n, 1'b0);

    // R4: one sample short, then restart after a one-edge drop in hold-off
    cur_req = "R4";
    hold_lvl(1, 0, need_hi() - 1);
    hold_lvl(0, 0, 6);
    chk("R4", rst_n, 1'b0);
    hold_lvl(1, 0, HQ + 2);
    hold_lvl(0, 0, 1);
    chk("R4", rst_n, 1'b0);

    // R3: exact release latency
    cur_req = "R3";
    measure(1, 0, 1'b1, n);
    chk_int("R3", n, rel_negedges());

    // R6: dips of exactly LQ samples, back to back with one gap
    cur_req = "R6";
    hold_lvl(0, 1, LQ);
    hold_lvl(0, 0, 5);
    chk("R6", rst_n, 1'b1);
    hold_lvl(0, 1, LQ);
    hold_lvl(0, 0, 1);
    hold_lvl(0, 1, LQ);
    hold_lvl(0, 0, 4);
    chk("R6", rst_n, 1'b1);

    // R7: long mid band and high flag while released
    cur_req = "R7";
    hold_lvl(0, 0, 300);
    chk("R7", rst_n, 1'b1);
    hold_lvl(1, 0, 50);
    chk("R7", rst_n, 1'b1);

    // R5: exact trip latency
    cur_req = "R5";
    measure(0, 1, 1'b0, n);
    chk_int("R5", n, trip_negedges());
    hold_lvl(0, 0, 5);

    // R8: full sequence again after re-assertion
    cur_req = "R8";
    hold_lvl(1, 0, HQ + HD);
    hold_lvl(0, 0, 2);
    chk("R8", rst_n, 1'b0);
    measure(1, 0, 1'b1, n);
    chk_int("R8", n, rel_negedges());

    // R2: synchronizer delay is inside the measured latencies; random mix
    cur_req = "R2 R3 R5 random";
    for (int seg = 0; seg < 400; seg++) begin
      int lvl, len;
      lvl = $urandom_range(0, 2);
      len = $urandom_range(1, 3 * LQ);
      hold_lvl(lvl == 2, lvl == 0, len);
    end
    hold_lvl(0, 0, 4);
    summary();
  end

endmodule